// File: doc/BRIEF.md
# Transmitter Delay Compensation Unit

In the fast data phase of a flexible-data-rate CAN frame, a transmitting node sees its own bits come back through the transceiver loop. That loop delay can be longer than a whole fast bit. This block measures the delay once per frame and adds a programmable offset to it. The sum gives the secondary sample point: the CAN clock at which the node's bit checker compares the received level with the level it sent. The block publishes the value as a 7-bit status number.

The delay counter runs in CAN clock cycles. It starts when the node drives its own recessive-to-dominant edge in a marked window. It stops when that edge comes back on the receive line. While the node transmits in the data phase, the block produces one strobe per bit at the compensated position, counted from that bit's start. At each strobe it flags a mismatch between the received level and the level that was sent. When compensation is switched off, the strobe moves to a normal sample position supplied from outside.

Top module: `tdc_unit`

## Requirements
- R1: After reset, `tdc_value` is 0 and both `ssp_strobe` and `fast_bit_err` are 0.
- R2: The measured delay is k when `tx_bit` falls (1 to 0) in a cycle with `meas_arm` and `core_en` high and `rx_bit` falls k cycles later (k = 0 when both fall in the same cycle). From then on `tdc_value` equals delay plus offset.
- R3: When delay plus offset is larger than 127, `tdc_value` is 127. A sum of exactly 127 is passed through unchanged.
- R4: If no falling edge arrives on `rx_bit` after a measurement starts, the delay stops growing at 127.
- R5: A write on `ofs_wr` loads `ofs_wdata` into the offset only while `core_en` is 0. A write while `core_en` is 1 leaves `tdc_value` unchanged.
- R6: `frame_start` clears the delay to 0, and so does `core_en` at 0. Only the first armed transmit falling edge in a frame starts a measurement. A transmit falling edge without `meas_arm` starts nothing.
- R7: With `dp_active` high, `ssp_strobe` is high in exactly one cycle per bit. That cycle is the one whose distance from the `bit_start` cycle (counted as 0) equals the target. The target is `tdc_value` when `tdc_en` is 1. A new `bit_start` restarts the count.
- R8: With `tdc_en` at 0, the target is `nsp_pos` instead of `tdc_value`.
- R9: `fast_bit_err` is high only in a strobe cycle. It is high exactly when `rx_bit` differs from the `tx_bit` level of target cycles earlier.
- R10: While `dp_active` is 0, `ssp_strobe` and `fast_bit_err` stay 0 whatever `bit_start` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_en | input | 1 | Controller enable; offset writable only when 0 |
| tdc_en | input | 1 | 1 = use compensated position, 0 = use nsp_pos |
| ofs_wr | input | 1 | Offset write strobe |
| ofs_wdata | input | 7 | Offset in CAN clocks |
| frame_start | input | 1 | Pulse at the start of each frame |
| meas_arm | input | 1 | Marks the window of the own FD-format-to-reserved-bit edge |
| tx_bit | input | 1 | Transmitted bit stream |
| rx_bit | input | 1 | Received bit stream |
| dp_active | input | 1 | Node is the transmitter in the data phase |
| bit_start | input | 1 | Pulse in the first clock of each data-phase bit |
| nsp_pos | input | 7 | Normal sample point position in clocks from bit start |
| tdc_value | output | 7 | Saturated delay plus offset |
| ssp_strobe | output | 1 | Secondary sample point strobe |
| fast_bit_err | output | 1 | Bit mismatch at the strobe |

## Verification
The delay measurement is exercised with several loop delays: zero (both edges in one cycle), short, and mid-range. These show the exact cycle counting. It is also run with no returning edge, which isolates the counter cap, and with offsets that put the sum just below, at, and above 127, which pins the clamp boundary. Repeated armed edges, unarmed edges and locked offset writes show which stimuli must leave the value alone. The strobe path is driven with matched and mismatched transmit and receive levels, under both compensated and normal positions, with a zero position, and with the data phase inactive. Each expected strobe cycle is queued and matched by cycle number, so an early, late, missing or doubled strobe is told apart from a wrong error flag.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

   // saturating sum of two non-negative counts
   function automatic int unsigned sat_add(input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned lim);
      int unsigned s;
      s = a + b;
      return (s > lim) ? lim : s;
   endfunction

endpackage

// File: rtl/tdc_delay_meas.sv
module tdc_delay_meas #(
   parameter int unsigned POS_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_en,
   input  logic             frame_start,
   input  logic             meas_arm,
   input  logic             tx_bit,
   input  logic             rx_bit,
   output logic [POS_W-1:0] delay
);
   localparam int unsigned LIM = (1 << POS_W) - 1;
   localparam logic [POS_W-1:0] CNT_MAX = POS_W'(LIM);

   logic             tx_q, rx_q;
   logic             started_q, run_q;
   logic [POS_W-1:0] cnt_q;
   logic             tx_fall, rx_fall, go;

   assign tx_fall = tx_q & ~tx_bit;
   assign rx_fall = rx_q & ~rx_bit;
   assign go      = core_en & meas_arm & tx_fall & ~started_q & ~frame_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q      <= 1'b1;
         rx_q      <= 1'b1;
         started_q <= 1'b0;
         run_q     <= 1'b0;
         cnt_q     <= '0;
      end else begin
         tx_q <= tx_bit;
         rx_q <= rx_bit;
         if (frame_start || !core_en) begin
            started_q <= 1'b0;
            run_q     <= 1'b0;
            cnt_q     <= '0;
         end else if (go) begin
            started_q <= 1'b1;
            if (rx_fall) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else begin
               run_q <= 1'b1;
               cnt_q <= POS_W'(1);
            end
         end else if (run_q) begin
            if (rx_fall) begin
               run_q <= 1'b0;
            end else if (cnt_q != CNT_MAX) begin
               cnt_q <= cnt_q + POS_W'(1);
            end
         end
      end
   end

   assign delay = cnt_q;

   // a finished measurement is frozen until the next frame
   assert_hold_after_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (started_q && !run_q && !frame_start && core_en) |=> $stable(cnt_q));

   // the counter stays at its cap while no echo arrives
   assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q == CNT_MAX && !frame_start && core_en) |=> (cnt_q == CNT_MAX));

   // a new frame clears the delay
   assert_frame_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cnt_q == '0));

endmodule

// File: rtl/tdc_ssp_calc.sv
module tdc_ssp_calc #(
   parameter int unsigned POS_W   = 7,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_en,
   input  logic             ofs_wr,
   input  logic [POS_W-1:0] ofs_wdata,
   input  logic [POS_W-1:0] delay,
   output logic [POS_W-1:0] tdc_value
);
   localparam int unsigned LIM = (1 << POS_W) - 1;

   logic [POS_W-1:0] ofs_q;
   logic [POS_W-1:0] sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_q <= '0;
      end else if (ofs_wr && !core_en) begin
         ofs_q <= ofs_wdata;
      end
   end

   assign sum = POS_W'(tdc_pkg::sat_add(int'(delay), int'(ofs_q), LIM));

   generate
      if (OUT_REG) begin : g_reg_out
         logic [POS_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= sum;
         end
         assign tdc_value = val_q;
      end else begin : g_comb_out
         assign tdc_value = sum;
      end
   endgenerate

   // the offset is locked while the controller is enabled
   assert_ofs_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      core_en |=> $stable(ofs_q));

   // the offset survives every write attempt made while enabled
   assert_ofs_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_wr && core_en) |=> (ofs_q == $past(ofs_q)));

endmodule

// File: rtl/tdc_strobe_gen.sv
module tdc_strobe_gen #(
   parameter int unsigned POS_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dp_active,
   input  logic             bit_start,
   input  logic [POS_W-1:0] target,
   input  logic             tx_bit,
   input  logic             rx_bit,
   output logic             ssp_strobe,
   output logic             fast_bit_err
);
   localparam int unsigned LIM  = (1 << POS_W) - 1;
   localparam int unsigned HIST = LIM;
   localparam logic [POS_W-1:0] POS_MAX = POS_W'(LIM);

   logic [POS_W-1:0] pos_q, cur_pos;
   logic             live_q, fired_q;
   logic             in_bit, done_now, tx_ref;
   logic [HIST-1:0]  hist_q;

   assign cur_pos  = bit_start ? '0 : pos_q;
   assign done_now = bit_start ? 1'b0 : fired_q;
   assign in_bit   = dp_active & (bit_start | live_q);

   assign ssp_strobe   = in_bit & ~done_now & (cur_pos == target);
   assign tx_ref       = (target == '0) ? tx_bit : hist_q[target - POS_W'(1)];
   assign fast_bit_err = ssp_strobe & (rx_bit ^ tx_ref);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q   <= '0;
         live_q  <= 1'b0;
         fired_q <= 1'b0;
      end else if (!dp_active) begin
         pos_q   <= '0;
         live_q  <= 1'b0;
         fired_q <= 1'b0;
      end else if (bit_start) begin
         live_q  <= 1'b1;
         pos_q   <= POS_W'(1);
         fired_q <= ssp_strobe;
      end else begin
         if (pos_q != POS_MAX) pos_q <= pos_q + POS_W'(1);
         if (ssp_strobe)       fired_q <= 1'b1;
      end
   end

   // transmit history, entry i holds the level of i+1 cycles ago
   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '1;
      else        hist_q <= {hist_q[HIST-2:0], tx_bit};
   end

   assert_strobe_in_dp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ssp_strobe |-> dp_active);

   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ssp_strobe |=> (!ssp_strobe || bit_start));

   assert_err_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fast_bit_err |-> ssp_strobe);

endmodule

// File: rtl/tdc_unit.sv
module tdc_unit #(
   parameter int unsigned POS_W   = 7,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_en,
   input  logic             tdc_en,
   input  logic             ofs_wr,
   input  logic [POS_W-1:0] ofs_wdata,
   input  logic             frame_start,
   input  logic             meas_arm,
   input  logic             tx_bit,
   input  logic             rx_bit,
   input  logic             dp_active,
   input  logic             bit_start,
   input  logic [POS_W-1:0] nsp_pos,
   output logic [POS_W-1:0] tdc_value,
   output logic             ssp_strobe,
   output logic             fast_bit_err
);
   generate
      if (POS_W < 2 || POS_W > 10) begin : g_bad_width
         $error("tdc_unit: POS_W must lie in 2..10");
      end
   endgenerate

   logic [POS_W-1:0] delay;
   logic [POS_W-1:0] target;

   tdc_delay_meas #(.POS_W(POS_W)) meas_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_en     (core_en),
      .frame_start (frame_start),
      .meas_arm    (meas_arm),
      .tx_bit      (tx_bit),
      .rx_bit      (rx_bit),
      .delay       (delay)
   );

   tdc_ssp_calc #(.POS_W(POS_W), .OUT_REG(OUT_REG)) calc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_en   (core_en),
      .ofs_wr    (ofs_wr),
      .ofs_wdata (ofs_wdata),
      .delay     (delay),
      .tdc_value (tdc_value)
   );

   assign target = tdc_en ? tdc_value : nsp_pos;

   tdc_strobe_gen #(.POS_W(POS_W)) strb_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .dp_active    (dp_active),
      .bit_start    (bit_start),
      .target       (target),
      .tx_bit       (tx_bit),
      .rx_bit       (rx_bit),
      .ssp_strobe   (ssp_strobe),
      .fast_bit_err (fast_bit_err)
   );

   // the published value never falls below the measured delay
   assert_value_not_below_delay_R3: assert property (@(posedge clk) disable iff (!rst_n || OUT_REG)
      tdc_value >= delay);

endmodule

// File: tb/tdc_unit_tb.sv
`timescale 1ns/1ps
module tdc_unit_tb_top;
   localparam int W = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         core_en = 1'b0, tdc_en = 1'b1, ofs_wr = 1'b0;
   logic [W-1:0] ofs_wdata = '0, nsp_pos = 7'd3;
   logic         frame_start = 1'b0, meas_arm = 1'b0;
   logic         tx_bit = 1'b1, rx_bit = 1'b1;
   logic         dp_active = 1'b0, bit_start = 1'b0;
   logic [W-1:0] tdc_value;
   logic         ssp_strobe, fast_bit_err;

   always #2 clk = ~clk;

   tdc_unit #(.POS_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_en(core_en), .tdc_en(tdc_en),
      .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata), .frame_start(frame_start),
      .meas_arm(meas_arm), .tx_bit(tx_bit), .rx_bit(rx_bit),
      .dp_active(dp_active), .bit_start(bit_start), .nsp_pos(nsp_pos),
      .tdc_value(tdc_value), .ssp_strobe(ssp_strobe), .fast_bit_err(fast_bit_err)
   );

   typedef struct { int idx; bit err; } exp_t;
   exp_t  exp_q[$];
   int    n_chk = 0, n_fail = 0, smp = 0;
   string mon_req = "R7";
   bit    finished = 1'b0;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ofs(int v);
      tick(); core_en = 1'b0;
      tick(); ofs_wr = 1'b1; ofs_wdata = W'(v);
      tick(); ofs_wr = 1'b0; core_en = 1'b1;
   endtask

   // own edge, echo arrives d cycles later
   task automatic measure(int d);
      tick(); frame_start = 1'b1;
      tick(); frame_start = 1'b0;
      tick(); meas_arm = 1'b1; tx_bit = 1'b0;
      if (d == 0) rx_bit = 1'b0;
      for (int k = 1; k <= d; k++) begin
         tick(); meas_arm = 1'b0;
         if (k == d) rx_bit = 1'b0;
      end
      tick(); meas_arm = 1'b0;
      tick(2); tx_bit = 1'b1; rx_bit = 1'b1;
      tick(2);
   endtask

   // driver: one data-phase bit, expected strobe queued
   task automatic send_bit(bit txv, bit rxv, int len, int tgt, bit expect_strobe);
      tick(); bit_start = 1'b1; tx_bit = txv; rx_bit = rxv;
      if (expect_strobe) exp_q.push_back('{idx: smp + tgt, err: (txv != rxv)});
      for (int k = 1; k < len; k++) begin
         tick(); bit_start = 1'b0;
      end
   endtask

   // monitor: compares strobes against the queue
   initial begin
      forever begin
         @(negedge clk); #1;
         if (rst_n) begin
            if (ssp_strobe) begin
               n_chk++;
               if (exp_q.size() == 0 || exp_q[0].idx != smp) begin
                  n_fail++;
                  $display("FAIL %s R10: unexpected strobe actual_idx=%0d expected_idx=%0d",
                           mon_req, smp, (exp_q.size() != 0) ? exp_q[0].idx : -1);
               end else begin
                  n_chk++;
                  if (fast_bit_err != exp_q[0].err) begin
                     n_fail++;
                     $display("FAIL R9: fast_bit_err actual=%0d expected=%0d",
                              fast_bit_err, exp_q[0].err);
                  end
                  void'(exp_q.pop_front());
               end
            end else if (fast_bit_err) begin
               n_chk++; n_fail++;
               $display("FAIL R9: error without strobe actual=1 expected=0");
            end
            while (exp_q.size() != 0 && exp_q[0].idx < smp) begin
               n_chk++; n_fail++;
               $display("FAIL %s: missing strobe actual=none expected_idx=%0d",
                        mon_req, exp_q[0].idx);
               void'(exp_q.pop_front());
            end
         end
         smp++;
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(3); rst_n = 1'b1;
      tick(); #1;
      check("R1 value", tdc_value, 0);
      check("R1 strobe", ssp_strobe, 0);
      check("R1 err", fast_bit_err, 0);

      write_ofs(5);
      tick(); #1; check("R5 offset loaded", tdc_value, 5);
      tick(); ofs_wr = 1'b1; ofs_wdata = 7'd9;
      tick(); ofs_wr = 1'b0;
      tick(); #1; check("R5 locked write", tdc_value, 5);

      measure(3); #1; check("R2 delay 3", tdc_value, 8);

      // second armed edge in the same frame
      tick(); meas_arm = 1'b1; tx_bit = 1'b0;
      tick(); meas_arm = 1'b0;
      tick(4); rx_bit = 1'b0;
      tick(2); tx_bit = 1'b1; rx_bit = 1'b1;
      tick(); #1; check("R6 second edge ignored", tdc_value, 8);

      tick(); frame_start = 1'b1;
      tick(); frame_start = 1'b0;
      tick(); #1; check("R6 frame clear", tdc_value, 5);

      // unarmed edge
      tick(); tx_bit = 1'b0;
      tick(2); rx_bit = 1'b0;
      tick(2); tx_bit = 1'b1; rx_bit = 1'b1;
      tick(); #1; check("R6 unarmed ignored", tdc_value, 5);

      measure(0); #1; check("R2 delay 0", tdc_value, 5);
      measure(7); #1; check("R2 delay 7", tdc_value, 12);

      write_ofs(120);
      measure(6);  #1; check("R3 sum 126", tdc_value, 126);
      measure(7);  #1; check("R3 sum 127", tdc_value, 127);
      measure(8);  #1; check("R3 sum 128 clamped", tdc_value, 127);
      measure(10); #1; check("R3 sum 130 clamped", tdc_value, 127);

      // R4: no echo at all
      write_ofs(0);
      tick(); frame_start = 1'b1;
      tick(); frame_start = 1'b0;
      tick(); meas_arm = 1'b1; tx_bit = 1'b0;
      tick(); meas_arm = 1'b0;
      tick(40); #1; check("R4 counting", tdc_value, 41);
      tick(140); #1; check("R4 capped", tdc_value, 127);
      tick(); tx_bit = 1'b1;

      // R7 R9: compensated strobes, target 2 + 4 = 6
      write_ofs(2);
      measure(4); #1; check("R2 delay 4", tdc_value, 6);
      mon_req = "R7";
      tick(); dp_active = 1'b1;
      send_bit(1, 1, 10, 6, 1);
      send_bit(0, 0, 10, 6, 1);
      send_bit(1, 0, 10, 6, 1);
      send_bit(0, 1, 10, 6, 1);
      send_bit(1, 1, 9, 6, 1);
      tick(); dp_active = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1;
      tick(3);

      // R8: fall back to the normal sample point
      mon_req = "R8";
      tdc_en = 1'b0; nsp_pos = 7'd3;
      tick(); dp_active = 1'b1;
      send_bit(0, 0, 8, 3, 1);
      send_bit(1, 0, 8, 3, 1);
      tick(); dp_active = 1'b0;
      nsp_pos = 7'd0;
      tick(); dp_active = 1'b1;
      send_bit(0, 1, 5, 0, 1);
      send_bit(1, 1, 5, 0, 1);
      tick(); dp_active = 1'b0; tdc_en = 1'b1; tx_bit = 1'b1; rx_bit = 1'b1;
      tick(3);

      // R10: bit starts without the data phase
      mon_req = "R10";
      send_bit(0, 1, 10, 6, 0);
      send_bit(1, 0, 10, 6, 0);
      tick(2);
      check("R10 queue drained", exp_q.size(), 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule